// File: doc/BRIEF.md
# Staged Key-Hold Reset Sequencer

This block watches one active-low reset source, such as a power key or a reset button, whose level has already been debounced. While the source stays asserted it runs two timers in turn. The first timer measures the warning interval. When it runs out, the block sends a one-cycle warning ("bark") interrupt pulse. The second timer then measures the remaining grace interval. When that one runs out, the block sends a one-cycle reset request and latches the reset kind that was programmed for the source.

Both intervals are counted in milliseconds, and each is picked from a fixed non-linear table by a small code. The counters advance only on a one-cycle millisecond strobe that the surrounding logic derives from the system clock. Releasing the source at any moment abandons the sequence. The next press starts again from zero. Pin debounce, interrupt routing and the power sequencing that follows a reset are all handled outside this block.

Top module: `keyhold_reset_seq`

## Requirements
- R1: During reset and after it, `bark_pulse` and `rst_req` are 0 and `rst_kind_q` is 0.
- R2: After the source is pressed, the warning interval ends on tick number L1. L1 comes from `bark_code` through this table: 0→0, 1→32, 2→56, 3→80, 4→128, 5→184, 6→272, 7→408, 8→608, 9→904, 10→1352, 11→2048, 12→3072, 13→4480, 14→6720, 15→10256. A table value of 0 is treated as 1. If `bark_en`=1, `bark_pulse` is high in the cycle that follows that tick.
- R3: With `bark_en`=0, an expiry of the warning interval never raises `bark_pulse`. The grace interval still follows.
- R4: The grace interval starts only once the warning interval has expired. It ends on tick L1+L2 after the press. L2 comes from `rst_code` through this table: 0→0, 1→10, 2→50, 3→100, 4→250, 5→500, 6→1000, 7→2000. A table value of 0 is treated as 1. The request is raised in the cycle after that tick, and it never coincides with a bark pulse.
- R5: With `rst_en`=0, `rst_req` never rises and `rst_kind_q` keeps its value.
- R6: Only the `rst_kind` codes SOFT=0, WARM=1, SHUTDOWN=4 and HARD=7 are valid. Any other code produces no request and leaves `rst_kind_q` unchanged.
- R7: `rst_kind_q` takes the value of `rst_kind` in the cycle in which `rst_req` is high. It holds that value until the next request.
- R8: When `key_n` goes high, both stages go back to idle and both counters clear. No pulse follows the release, and the next press times again from zero.
- R9: `bark_pulse` and `rst_req` each last one cycle. Each fires at most once per continuous hold.
- R10: The timers advance only in cycles where `tick_ms`=1. Without ticks, a held source makes no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| key_n | input | 1 | Debounced source level, low = held |
| bark_en | input | 1 | Allow the warning pulse |
| rst_en | input | 1 | Allow the reset request |
| bark_code | input | 4 | Warning-interval table code |
| rst_code | input | 3 | Grace-interval table code |
| rst_kind | input | 3 | Requested reset kind (0,1,4,7 valid) |
| bark_pulse | output | 1 | One-cycle warning interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind_q | output | 3 | Kind latched at the last request |

## Verification
A corrupted stage state or counter in this block shows up at the ports as a pulse that arrives at the wrong tick or is missing entirely. Because the bench compares every tick of every hold, such an error is caught on the first tick where the pulse is due or wrongly present. A counter left uncleared after a release makes the next hold fire early, and that is caught within that hold. An error in the latch for the reset kind appears on `rst_kind_q` in the cycle after the request.

// File: rtl/keyhold_pkg.sv
package keyhold_pkg;

   typedef enum logic [1:0] {
      KH_IDLE      = 2'd0,
      KH_WARN_WAIT = 2'd1,
      KH_GRACE     = 2'd2,
      KH_SPENT     = 2'd3
   } kh_state_e;

   localparam int KH_TABLE_MS_W = 14;

   // warning-interval lookup, milliseconds
   function automatic logic [KH_TABLE_MS_W-1:0] warn_ms(input logic [3:0] code);
      case (code)
         4'd0:  warn_ms = 14'd0;
         4'd1:  warn_ms = 14'd32;
         4'd2:  warn_ms = 14'd56;
         4'd3:  warn_ms = 14'd80;
         4'd4:  warn_ms = 14'd128;
         4'd5:  warn_ms = 14'd184;
         4'd6:  warn_ms = 14'd272;
         4'd7:  warn_ms = 14'd408;
         4'd8:  warn_ms = 14'd608;
         4'd9:  warn_ms = 14'd904;
         4'd10: warn_ms = 14'd1352;
         4'd11: warn_ms = 14'd2048;
         4'd12: warn_ms = 14'd3072;
         4'd13: warn_ms = 14'd4480;
         4'd14: warn_ms = 14'd6720;
         default: warn_ms = 14'd10256;
      endcase
   endfunction

   // grace-interval lookup, milliseconds
   function automatic logic [KH_TABLE_MS_W-1:0] grace_ms(input logic [2:0] code);
      case (code)
         3'd0: grace_ms = 14'd0;
         3'd1: grace_ms = 14'd10;
         3'd2: grace_ms = 14'd50;
         3'd3: grace_ms = 14'd100;
         3'd4: grace_ms = 14'd250;
         3'd5: grace_ms = 14'd500;
         3'd6: grace_ms = 14'd1000;
         default: grace_ms = 14'd2000;
      endcase
   endfunction

   function automatic logic kind_is_valid(input logic [2:0] kind);
      kind_is_valid = (kind == 3'd0) || (kind == 3'd1) ||
                      (kind == 3'd4) || (kind == 3'd7);
   endfunction

endpackage

// File: rtl/keyhold_timeout_lut.sv
module keyhold_timeout_lut
   import keyhold_pkg::*;
#(
   parameter int STAGE  = 1,
   parameter int CODE_W = 4,
   parameter int CNT_W  = 14
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  limit
);

   localparam int EXP_CODE_W = (STAGE == 1) ? 4 : 3;

   if (CNT_W < KH_TABLE_MS_W) begin : g_bad_cnt
      $error("keyhold_timeout_lut: CNT_W too small for the table");
   end
   if (CODE_W != EXP_CODE_W) begin : g_bad_code
      $error("keyhold_timeout_lut: CODE_W does not match the stage table");
   end
   if (STAGE != 1 && STAGE != 2) begin : g_bad_stage
      $error("keyhold_timeout_lut: STAGE must be 1 or 2");
   end

   logic [KH_TABLE_MS_W-1:0] raw_ms;

   if (STAGE == 1) begin : g_warn
      assign raw_ms = warn_ms(code[3:0]);
   end else begin : g_grace
      assign raw_ms = grace_ms(code[2:0]);
   end

   // a zero entry finishes on the first tick
   assign limit = (raw_ms == '0) ? CNT_W'(1) : CNT_W'(raw_ms);

endmodule

// File: rtl/keyhold_stage_timer.sv
module keyhold_stage_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   if (CNT_W < 2) begin : g_bad_w
      $error("keyhold_stage_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_next;

   assign cnt_next = {1'b0, cnt} + 1'b1;
   assign expire   = run && tick && (cnt_next >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear || expire)
         cnt <= '0;
      else if (run && tick)
         cnt <= cnt_next[CNT_W-1:0];
   end

   // counting moves only on the strobe
   assert_count_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clear) |=> $stable(cnt));

   // a cleared timer starts from zero
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/keyhold_reset_seq.sv
module keyhold_reset_seq
   import keyhold_pkg::*;
#(
   parameter int S1_CODE_W = 4,
   parameter int S2_CODE_W = 3,
   parameter int KIND_W    = 3,
   parameter int CNT_W     = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_ms,
   input  logic                 key_n,
   input  logic                 bark_en,
   input  logic                 rst_en,
   input  logic [S1_CODE_W-1:0] bark_code,
   input  logic [S2_CODE_W-1:0] rst_code,
   input  logic [KIND_W-1:0]    rst_kind,
   output logic                 bark_pulse,
   output logic                 rst_req,
   output logic [KIND_W-1:0]    rst_kind_q
);

   if (KIND_W != 3) begin : g_bad_kind
      $error("keyhold_reset_seq: KIND_W must be 3");
   end

   kh_state_e        st, st_nxt;
   logic             held;
   logic [CNT_W-1:0] warn_lim, grace_lim;
   logic             warn_exp, grace_exp;
   logic             fire_bark, fire_req;

   assign held = ~key_n;

   keyhold_timeout_lut #(.STAGE(1), .CODE_W(S1_CODE_W), .CNT_W(CNT_W)) u_warn_lut (
      .code (bark_code),
      .limit(warn_lim)
   );

   keyhold_timeout_lut #(.STAGE(2), .CODE_W(S2_CODE_W), .CNT_W(CNT_W)) u_grace_lut (
      .code (rst_code),
      .limit(grace_lim)
   );

   keyhold_stage_timer #(.CNT_W(CNT_W)) u_warn_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (~held),
      .run   (held && (st == KH_WARN_WAIT)),
      .tick  (tick_ms),
      .limit (warn_lim),
      .expire(warn_exp)
   );

   keyhold_stage_timer #(.CNT_W(CNT_W)) u_grace_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (~held),
      .run   (held && (st == KH_GRACE)),
      .tick  (tick_ms),
      .limit (grace_lim),
      .expire(grace_exp)
   );

   always_comb begin
      st_nxt = st;
      if (!held) begin
         st_nxt = KH_IDLE;
      end else begin
         case (st)
            KH_IDLE:      st_nxt = KH_WARN_WAIT;
            KH_WARN_WAIT: if (warn_exp)  st_nxt = KH_GRACE;
            KH_GRACE:     if (grace_exp) st_nxt = KH_SPENT;
            default:      st_nxt = KH_SPENT;
         endcase
      end
   end

   assign fire_bark = warn_exp && bark_en;
   assign fire_req  = grace_exp && rst_en && kind_is_valid(rst_kind[2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= KH_IDLE;
         bark_pulse <= 1'b0;
         rst_req    <= 1'b0;
         rst_kind_q <= '0;
      end else begin
         st         <= st_nxt;
         bark_pulse <= fire_bark;
         rst_req    <= fire_req;
         if (fire_req)
            rst_kind_q <= rst_kind;
      end
   end

   assert_bark_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bark_pulse |-> $past(bark_en));

   assert_req_support_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(rst_en));

   assert_req_kind_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> kind_is_valid(rst_kind_q[2:0]));

   assert_kind_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_req |-> $stable(rst_kind_q));

   assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(key_n) |-> (st == KH_IDLE));

   assert_bark_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bark_pulse |=> !bark_pulse);

   assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_pulse_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bark_pulse || rst_req) |-> $past(tick_ms));

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bark_pulse |-> !rst_req);

endmodule

// File: tb/keyhold_reset_seq_bench.sv
`timescale 1ns/1ps
module keyhold_reset_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic       key_n = 1'b1;
   logic       bark_en = 1'b0;
   logic       rst_en = 1'b0;
   logic [3:0] bark_code = '0;
   logic [2:0] rst_code = '0;
   logic [2:0] rst_kind = '0;
   logic       bark_pulse, rst_req;
   logic [2:0] rst_kind_q;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic [2:0] exp_kind = '0;

   always #2.5 clk = ~clk;

   keyhold_reset_seq u_keyhold_reset_seq (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .key_n(key_n),
      .bark_en(bark_en), .rst_en(rst_en), .bark_code(bark_code),
      .rst_code(rst_code), .rst_kind(rst_kind), .bark_pulse(bark_pulse),
      .rst_req(rst_req), .rst_kind_q(rst_kind_q)
   );

   function automatic int warn_tab(input logic [3:0] c);
      case (c)
         4'd0: return 0;      4'd1: return 32;    4'd2: return 56;    4'd3: return 80;
         4'd4: return 128;    4'd5: return 184;   4'd6: return 272;   4'd7: return 408;
         4'd8: return 608;    4'd9: return 904;   4'd10: return 1352; 4'd11: return 2048;
         4'd12: return 3072;  4'd13: return 4480; 4'd14: return 6720; default: return 10256;
      endcase
   endfunction

   function automatic int grace_tab(input logic [2:0] c);
      case (c)
         3'd0: return 0;   3'd1: return 10;  3'd2: return 50;   3'd3: return 100;
         3'd4: return 250; 3'd5: return 500; 3'd6: return 1000; default: return 2000;
      endcase
   endfunction

   function automatic bit kind_ok(input logic [2:0] k);
      return (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd7);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // one tick strobe, checks after it and in the quiet cycle that follows
   task automatic one_tick(input bit exp_b, input bit exp_r, input string tb, input string tr);
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      check(tb, "bark_pulse", int'(bark_pulse), int'(exp_b));
      check(tr, "rst_req", int'(rst_req), int'(exp_r));
      check("R7", "rst_kind_q", int'(rst_kind_q), int'(exp_kind));
      @(negedge clk);
      check("R9", "bark_pulse width", int'(bark_pulse), 0);
      check("R9", "rst_req width", int'(rst_req), 0);
   endtask

   task automatic hold(input logic [3:0] c1, input logic [2:0] c2, input logic [2:0] kind,
                       input bit be, input bit re, input int hold_ticks);
      int    l1, l2;
      string tb, tr;
      bit    eb, er;
      l1 = warn_tab(c1);  if (l1 == 0) l1 = 1;
      l2 = grace_tab(c2); if (l2 == 0) l2 = 1;
      tb = be ? "R2" : "R3";
      tr = !re ? "R5" : (!kind_ok(kind) ? "R6" : "R4");
      bark_code = c1; rst_code = c2; rst_kind = kind; bark_en = be; rst_en = re;
      key_n = 1'b0;
      @(negedge clk);
      for (int t = 1; t <= hold_ticks; t++) begin
         eb = be && (t == l1);
         er = re && kind_ok(kind) && (t == l1 + l2);
         if (er) exp_kind = kind;
         one_tick(eb, er, tb, tr);
      end
      key_n = 1'b1;
      @(negedge clk);
      for (int t = 0; t < 3; t++) one_tick(1'b0, 1'b0, "R8", "R8");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", "bark_pulse in reset", int'(bark_pulse), 0);
      check("R1", "rst_req in reset", int'(rst_req), 0);
      check("R1", "rst_kind_q in reset", int'(rst_kind_q), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "rst_kind_q after reset", int'(rst_kind_q), 0);

      // zero codes finish on the first tick of each stage
      hold(4'd0, 3'd0, 3'd1, 1'b1, 1'b1, 4);

      // R10: held with no strobe makes no progress
      bark_code = 4'd0; rst_code = 3'd0; bark_en = 1'b1; rst_en = 1'b1; rst_kind = 3'd4;
      key_n = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         check("R10", "bark_pulse without tick", int'(bark_pulse), 0);
      end
      key_n = 1'b1;
      @(negedge clk);

      hold(4'd1, 3'd1, 3'd7, 1'b0, 1'b1, 50);          // R3
      hold(4'd1, 3'd1, 3'd4, 1'b1, 1'b0, 50);          // R5
      hold(4'd0, 3'd0, 3'd2, 1'b1, 1'b1, 5);           // R6
      hold(4'd0, 3'd0, 3'd3, 1'b1, 1'b1, 5);           // R6
      hold(4'd0, 3'd0, 3'd5, 1'b1, 1'b1, 5);           // R6
      hold(4'd0, 3'd0, 3'd6, 1'b1, 1'b1, 5);           // R6
      hold(4'd2, 3'd2, 3'd4, 1'b1, 1'b1, 56 + 49);     // R8: release one tick early
      hold(4'd2, 3'd2, 3'd4, 1'b1, 1'b1, 56 + 50 + 3); // R7: SHUTDOWN latched
      hold(4'd1, 3'd0, 3'd0, 1'b1, 1'b1, 20);          // R8: release before bark
      hold(4'd1, 3'd1, 3'd0, 1'b1, 1'b1, 45);          // R7: SOFT latched
      hold(4'd9, 3'd7, 3'd7, 1'b1, 1'b1, 904 + 2000 + 2);
      hold(4'd15, 3'd0, 3'd1, 1'b1, 1'b1, 10256 + 3);

      for (int n = 0; n < 30; n++) begin
         logic [3:0] c1;
         logic [2:0] c2, k;
         bit be, re;
         int l1, l2, ht;
         c1 = 4'($urandom_range(0, 8));
         c2 = 3'($urandom_range(0, 5));
         k  = 3'($urandom_range(0, 7));
         be = ($urandom_range(0, 3) != 0);
         re = ($urandom_range(0, 3) != 0);
         l1 = warn_tab(c1);  if (l1 == 0) l1 = 1;
         l2 = grace_tab(c2); if (l2 == 0) l2 = 1;
         ht = $urandom_range(1, l1 + l2 + 4);
         hold(c1, c2, k, be, re, ht);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not finish actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule